// File: doc/BRIEF.md
# Parallel Display Bus Cycle Generator

This block runs single accesses on an 8080-style parallel bus that connects a chip to a smart display controller. The host requests one access at a time: a command write, a data write or a read. The block then produces the active-low chip-select, write-strobe and read-strobe waveforms, together with a command/data select line. Every waveform edge is placed at a programmable number of ticks from the start of the access. A tick lasts one clock, or two clocks when the divider bit is set.

A read is started by a request of the read kind. The bus value is captured at a programmed sample tick, and the host picks it up from the read-data output once busy has dropped. After each cycle, chip-select is held high for a programmable number of gap ticks, and busy stays high until that gap is over. In 8-bit mode the upper half of the bus carries zero, and captured read data has a zero upper half.

All timing inputs must stay stable while busy is high. The strobe off times must not exceed the cycle length, and the sample tick must fall after the read-strobe on time and inside the read cycle.

Top module: `lcdBusTiming`

## Requirements
- R1: After reset, chip-select, write strobe and read strobe are high, busy is low, the command/data select is high, the output enable is low and the read data is zero. Whenever busy is low, all three bus strobes stay high.
- R2: A request (reqValid high while busy is low) is accepted at that clock edge. Busy is high from the next clock for exactly (C + G) * D clocks, where C is the effective cycle length in ticks, G is the gap in ticks and D is the tick length in clocks.
- R3: Let tick k be the k-th tick of the access, counted from 0. Chip-select is low during tick k exactly when csOnTicks <= k < csOffTicks.
- R4: On a write access (reqKind 0 or 1), the write strobe is low exactly when wrOnTicks <= k < wrOffTicks. The read strobe stays high, and lcdDataOut carries the request data with the output enable high for every clock of the cycle.
- R5: On a read access (reqKind bit 1 set), the read strobe is low exactly when rdOnTicks <= k < rdOffTicks. The write strobe stays high and the output enable stays low.
- R6: A read captures lcdDataIn as it stands on the last clock of tick sampleTicks. The value appears on rdData and is held there until the next read.
- R7: During the cycle of a command write (reqKind 0), lcdDcSel is low. For data writes and reads it stays high throughout.
- R8: With tickDiv2 set, each tick lasts two clocks (D = 2). With tickDiv2 clear, each tick lasts one clock (D = 1).
- R9: busWidth 2'b11 selects a 16-bit bus. Any other value selects 8 bits: lcdDataOut[15:8] is driven zero and rdData[15:8] is captured as zero.
- R10: A request made while busy is high is ignored. It alters neither the running access nor starts a later one.
- R11: After the cycle, chip-select stays high for csGapTicks ticks while busy stays high. With a gap of 0, busy drops right after the cycle.
- R12: The cycle length is wrCycleTicks for writes and rdCycleTicks for reads. A programmed length of 0 is treated as 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickDiv2 | input | 1 | 1: tick is two clocks, 0: one clock |
| busWidth | input | 2 | 2'b11 selects 16-bit bus, otherwise 8-bit |
| csOnTicks | input | 4 | Chip-select assert tick |
| csOffTicks | input | 6 | Chip-select release tick |
| wrOnTicks | input | 4 | Write strobe assert tick |
| wrOffTicks | input | 6 | Write strobe release tick |
| rdOnTicks | input | 4 | Read strobe assert tick |
| rdOffTicks | input | 6 | Read strobe release tick |
| wrCycleTicks | input | 6 | Write cycle length in ticks |
| rdCycleTicks | input | 6 | Read cycle length in ticks |
| sampleTicks | input | 6 | Tick whose last clock captures read data |
| csGapTicks | input | 6 | Idle ticks with chip-select high after a cycle |
| reqValid | input | 1 | Request strobe |
| reqKind | input | 2 | 0 command write, 1 data write, 2 or 3 read |
| reqData | input | 16 | Write value |
| busy | output | 1 | Access or gap in progress |
| rdData | output | 16 | Last captured read value |
| lcdCsN | output | 1 | Chip-select, active low |
| lcdWrN | output | 1 | Write strobe, active low |
| lcdRdN | output | 1 | Read strobe, active low |
| lcdDcSel | output | 1 | 0 command, 1 data |
| lcdDataOut | output | 16 | Bus value driven on writes |
| lcdDataOe | output | 1 | Bus output enable |
| lcdDataIn | input | 16 | Bus value read from the display |

## Verification
The bench changes lcdDataIn on every clock, so a read that samples one clock early or late, or on the wrong tick under the divide-by-two setting, returns a visibly wrong value. It measures the first low clock and the low length of each strobe in clocks. An off-by-one in a compare, a divider that fails to stretch an edge, or a strobe leaking into the wrong access kind therefore shows up as a count mismatch. Further cases:
- A zero cycle length with a zero gap catches a counter that wraps to 64 ticks instead of ending after one.
- A request pulsed in the middle of an access catches a design that restarts or queues it.
- 8-bit accesses catch upper bits leaking onto the bus or into the read value.

// File: rtl/lcdBusPkg.sv
package lcdBusPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_GAP  = 2'd2
  } busStateE;

  localparam logic [1:0] KIND_CMD = 2'd0;

  // Per-clock strobes from the control to the datapath
  typedef struct packed {
    logic load;     // latch write value
    logic capture;  // sample bus input
    logic csAct;    // chip-select active
    logic weAct;    // write strobe active
    logic reAct;    // read strobe active
    logic isCmd;    // command cycle in progress
    logic isWrite;  // write cycle in progress
  } strobeS;

endpackage

// File: rtl/lcdBusTick.sv
module lcdBusTick (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic restart,
  input  logic div2,
  output logic tickEn
);

  logic phase;

  always_ff @(posedge clk) begin
    if (!rstN)               phase <= 1'b0;
    else if (restart)        phase <= 1'b0;
    else if (run && div2)    phase <= ~phase;
    else                     phase <= 1'b0;
  end

  // Tick ends on the last clock of each tick period
  assign tickEn = run && (!div2 || phase);

  AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rstN)
    (run && div2 && tickEn) ##1 div2 |-> !tickEn); // R8

endmodule

// File: rtl/lcdBusCtrl.sv
module lcdBusCtrl
  import lcdBusPkg::*;
#(
  parameter int CNT_W = 6,
  parameter int ON_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ON_W-1:0]  csOn,
  input  logic [CNT_W-1:0] csOff,
  input  logic [ON_W-1:0]  weOn,
  input  logic [CNT_W-1:0] weOff,
  input  logic [ON_W-1:0]  reOn,
  input  logic [CNT_W-1:0] reOff,
  input  logic [CNT_W-1:0] wrCycle,
  input  logic [CNT_W-1:0] rdCycle,
  input  logic [CNT_W-1:0] accTime,
  input  logic [CNT_W-1:0] csGap,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic             tickEn,
  output logic             busy,
  output logic             run,
  output logic             accept,
  output strobeS           strb
);

  busStateE         state;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       kindReg;
  logic             isRead;
  logic [CNT_W-1:0] cycSel;
  logic [CNT_W-1:0] cycLast;
  logic [CNT_W-1:0] gapLast;
  logic             active;
  logic             lastAcc;

  assign isRead  = kindReg[1];
  assign cycSel  = isRead ? rdCycle : wrCycle;
  assign cycLast = (cycSel == '0) ? '0 : cycSel - 1'b1;
  assign gapLast = csGap - 1'b1;
  assign active  = (state == ST_ACC);
  assign lastAcc = (cnt == cycLast);
  assign accept  = reqValid && (state == ST_IDLE);
  assign run     = (state != ST_IDLE);
  assign busy    = run;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      kindReg <= KIND_CMD;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_ACC;
            cnt     <= '0;
            kindReg <= reqKind;
          end
        end
        ST_ACC: begin
          if (tickEn) begin
            if (lastAcc) begin
              cnt   <= '0;
              state <= (csGap == '0) ? ST_IDLE : ST_GAP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (tickEn) begin
            if (cnt == gapLast) begin
              cnt   <= '0;
              state <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.load    = accept;
    strb.csAct   = active && (cnt >= CNT_W'(csOn)) && (cnt < csOff);
    strb.weAct   = active && !isRead && (cnt >= CNT_W'(weOn)) && (cnt < weOff);
    strb.reAct   = active && isRead && (cnt >= CNT_W'(reOn)) && (cnt < reOff);
    strb.capture = active && isRead && tickEn && (cnt == accTime);
    strb.isCmd   = active && (kindReg == KIND_CMD);
    strb.isWrite = active && !isRead;
  end

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid) |=> $stable(kindReg)); // R10

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tickEn) |=> $stable(cnt) && $stable(state)); // R8

  AST_ZERO_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (active && tickEn && cycSel == '0) |=> (state != ST_ACC)); // R12

endmodule

// File: rtl/lcdBusDatapath.sv
module lcdBusDatapath
  import lcdBusPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busWidth,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] lcdDataIn,
  input  strobeS            strb,
  input  logic              busy,
  output logic [DATA_W-1:0] rdData,
  output logic              lcdCsN,
  output logic              lcdWrN,
  output logic              lcdRdN,
  output logic              lcdDcSel,
  output logic [DATA_W-1:0] lcdDataOut,
  output logic              lcdDataOe
);

  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] LOW_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

  logic              wide;
  logic [DATA_W-1:0] outReg;
  logic [DATA_W-1:0] rdReg;

  assign wide = (busWidth == 2'b11);

  function automatic logic [DATA_W-1:0] fitWidth(input logic [DATA_W-1:0] v,
                                                 input logic w);
    return w ? v : (v & LOW_MASK);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg <= '0;
      rdReg  <= '0;
    end else begin
      if (strb.load)    outReg <= fitWidth(reqData, wide);
      if (strb.capture) rdReg  <= fitWidth(lcdDataIn, wide);
    end
  end

  assign rdData     = rdReg;
  assign lcdCsN     = !strb.csAct;
  assign lcdWrN     = !strb.weAct;
  assign lcdRdN     = !strb.reAct;
  assign lcdDcSel   = !strb.isCmd;
  assign lcdDataOe  = strb.isWrite;
  assign lcdDataOut = strb.isWrite ? outReg : '0;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (lcdCsN && lcdWrN && lcdRdN)); // R1

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!lcdWrN && !lcdRdN)); // R5

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    !lcdRdN |-> !lcdDataOe); // R5

  AST_NARROW_READ: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.capture) && !wide) |-> (rdData[DATA_W-1:HALF] == '0)); // R9

endmodule

// File: rtl/lcdBusTiming.sv
module lcdBusTiming
  import lcdBusPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6,
  parameter int ON_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickDiv2,
  input  logic [1:0]        busWidth,
  input  logic [ON_W-1:0]   csOnTicks,
  input  logic [CNT_W-1:0]  csOffTicks,
  input  logic [ON_W-1:0]   wrOnTicks,
  input  logic [CNT_W-1:0]  wrOffTicks,
  input  logic [ON_W-1:0]   rdOnTicks,
  input  logic [CNT_W-1:0]  rdOffTicks,
  input  logic [CNT_W-1:0]  wrCycleTicks,
  input  logic [CNT_W-1:0]  rdCycleTicks,
  input  logic [CNT_W-1:0]  sampleTicks,
  input  logic [CNT_W-1:0]  csGapTicks,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [DATA_W-1:0] reqData,
  output logic              busy,
  output logic [DATA_W-1:0] rdData,
  output logic              lcdCsN,
  output logic              lcdWrN,
  output logic              lcdRdN,
  output logic              lcdDcSel,
  output logic [DATA_W-1:0] lcdDataOut,
  output logic              lcdDataOe,
  input  logic [DATA_W-1:0] lcdDataIn
);

  logic   tickEn;
  logic   run;
  logic   accept;
  strobeS strb;

  lcdBusTick uTick (
    .clk(clk), .rstN(rstN), .run(run), .restart(accept),
    .div2(tickDiv2), .tickEn(tickEn)
  );

  lcdBusCtrl #(.CNT_W(CNT_W), .ON_W(ON_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .csOn(csOnTicks), .csOff(csOffTicks),
    .weOn(wrOnTicks), .weOff(wrOffTicks),
    .reOn(rdOnTicks), .reOff(rdOffTicks),
    .wrCycle(wrCycleTicks), .rdCycle(rdCycleTicks),
    .accTime(sampleTicks), .csGap(csGapTicks),
    .reqValid(reqValid), .reqKind(reqKind), .tickEn(tickEn),
    .busy(busy), .run(run), .accept(accept), .strb(strb)
  );

  lcdBusDatapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .busWidth(busWidth),
    .reqData(reqData), .lcdDataIn(lcdDataIn), .strb(strb), .busy(busy),
    .rdData(rdData), .lcdCsN(lcdCsN), .lcdWrN(lcdWrN), .lcdRdN(lcdRdN),
    .lcdDcSel(lcdDcSel), .lcdDataOut(lcdDataOut), .lcdDataOe(lcdDataOe)
  );

endmodule

// File: tb/tb_lcdBusTiming.sv
module tb_lcdBusTiming;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickDiv2 = 1'b0;
  logic [1:0]  busWidth = 2'b11;
  logic [3:0]  csOnTicks = 4'd1, wrOnTicks = 4'd2, rdOnTicks = 4'd2;
  logic [5:0]  csOffTicks = 6'd8, wrOffTicks = 6'd6, rdOffTicks = 6'd7;
  logic [5:0]  wrCycleTicks = 6'd9, rdCycleTicks = 6'd10;
  logic [5:0]  sampleTicks = 6'd5, csGapTicks = 6'd3;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [15:0] reqData = '0;
  logic        busy;
  logic [15:0] rdData;
  logic        lcdCsN, lcdWrN, lcdRdN, lcdDcSel, lcdDataOe;
  logic [15:0] lcdDataOut;
  logic [15:0] lcdDataIn = '0;

  always #10 clk = ~clk; // 50 MHz

  lcdBusTiming dut (.*);

  typedef struct {
    int busyLen; int csFirst; int csLen; int wrFirst; int wrLen;
    int rdFirst; int rdLen; int selLow; int oeLen;
    logic [15:0] wData; logic [15:0] rData; bit isWrite;
  } expT;

  expT         expQ[$];
  int          errors = 0;
  int          checks = 0;
  int          pushed = 0;
  int          seen = 0;
  logic [15:0] rdBase = '0;
  logic [15:0] lastRd = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int divClocks();
    return tickDiv2 ? 2 : 1;
  endfunction

  function automatic int winLen(input int lo, input int hi, input int cyc);
    int top = (hi < cyc) ? hi : cyc;
    return (top > lo) ? (top - lo) * divClocks() : 0;
  endfunction

  function automatic int winFirst(input int lo, input int hi, input int cyc);
    return (winLen(lo, hi, cyc) > 0) ? lo * divClocks() : -1;
  endfunction

  function automatic logic [15:0] fit(input logic [15:0] v);
    return (busWidth == 2'b11) ? v : {8'h00, v[7:0]};
  endfunction

  // Driver: computes expectation from the requirements, then issues request
  task automatic doAccess(input logic [1:0] kind, input logic [15:0] data,
                          input logic [15:0] base, input bit poke);
    expT e;
    int  d = divClocks();
    bit  rd = kind[1];
    int  cyc = rd ? int'(rdCycleTicks) : int'(wrCycleTicks);
    if (cyc == 0) cyc = 1; // R12
    e.isWrite = !rd;
    e.busyLen = (cyc + int'(csGapTicks)) * d;                            // R2 R11
    e.csFirst = winFirst(int'(csOnTicks), int'(csOffTicks), cyc);        // R3
    e.csLen   = winLen(int'(csOnTicks), int'(csOffTicks), cyc);
    e.wrFirst = rd ? -1 : winFirst(int'(wrOnTicks), int'(wrOffTicks), cyc); // R4
    e.wrLen   = rd ? 0 : winLen(int'(wrOnTicks), int'(wrOffTicks), cyc);
    e.rdFirst = rd ? winFirst(int'(rdOnTicks), int'(rdOffTicks), cyc) : -1; // R5
    e.rdLen   = rd ? winLen(int'(rdOnTicks), int'(rdOffTicks), cyc) : 0;
    e.selLow  = (kind == 2'd0) ? cyc * d : 0;                            // R7
    e.oeLen   = rd ? 0 : cyc * d;
    e.wData   = fit(data);                                               // R9
    if (rd) lastRd = fit(base + 16'((int'(sampleTicks) + 1) * d - 1));   // R6
    e.rData   = lastRd;
    @(negedge clk);
    while (busy) @(negedge clk);
    rdBase = base;
    expQ.push_back(e);
    pushed++;
    reqValid = 1'b1;
    reqKind  = kind;
    reqData  = data;
    @(negedge clk);
    reqValid = 1'b0;
    if (poke) begin // R10: request while busy
      repeat (3) @(negedge clk);
      reqValid = 1'b1;
      reqKind  = 2'd2;
      reqData  = 16'hFFFF;
      @(negedge clk);
      reqValid = 1'b0;
    end
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // Monitor: measures each access and compares it against the queue
  bit inAcc = 1'b0;
  int n, csF, csL, wrF, wrL, rdF, rdL, selL, oeL;
  logic [15:0] wSeen;

  initial begin
    forever begin
      @(negedge clk);
      if (busy) begin
        if (!inAcc) begin
          inAcc = 1'b1; n = 0; csF = -1; csL = 0; wrF = -1; wrL = 0;
          rdF = -1; rdL = 0; selL = 0; oeL = 0; wSeen = 'x;
        end
        lcdDataIn = rdBase + 16'(n);
        #1;
        if (!lcdCsN) begin if (csF < 0) csF = n; csL++; end
        if (!lcdWrN) begin if (wrF < 0) begin wrF = n; wSeen = lcdDataOut; end wrL++; end
        if (!lcdRdN) begin if (rdF < 0) rdF = n; rdL++; end
        if (!lcdDcSel) selL++;
        if (lcdDataOe) oeL++;
        n++;
      end else if (inAcc) begin
        expT e;
        inAcc = 1'b0;
        seen++;
        if (expQ.size() == 0) begin
          chk(1'b0, "R10 unexpected access", seen, pushed);
        end else begin
          e = expQ.pop_front();
          chk(n == e.busyLen, "R2 busy length", n, e.busyLen);
          chk(csF == e.csFirst, "R3 cs first", csF, e.csFirst);
          chk(csL == e.csLen, "R3 cs length", csL, e.csLen);
          chk(wrF == e.wrFirst, "R4 wr first", wrF, e.wrFirst);
          chk(wrL == e.wrLen, "R4 wr length", wrL, e.wrLen);
          chk(rdF == e.rdFirst, "R5 rd first", rdF, e.rdFirst);
          chk(rdL == e.rdLen, "R5 rd length", rdL, e.rdLen);
          chk(selL == e.selLow, "R7 select low", selL, e.selLow);
          chk(oeL == e.oeLen, "R4 R5 enable", oeL, e.oeLen);
          if (e.isWrite && e.wrLen > 0)
            chk(wSeen === e.wData, "R4 R9 write data", int'(wSeen), int'(e.wData));
          chk(rdData === e.rData, "R6 R9 read data", int'(rdData), int'(e.rData));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(lcdCsN && lcdWrN && lcdRdN, "R1 strobes", {lcdCsN, lcdWrN, lcdRdN}, 7);
    chk(!busy && lcdDcSel && !lcdDataOe, "R1 busy/sel/oe", {busy, lcdDcSel, lcdDataOe}, 2);
    chk(rdData == 16'h0, "R1 read data", int'(rdData), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(lcdCsN && !busy, "R1 idle after reset", {lcdCsN, busy}, 2);

    doAccess(2'd0, 16'hA5C3, 16'h0000, 1'b1); // R7 command, R10 poke
    doAccess(2'd1, 16'h5A3C, 16'h0000, 1'b0);
    doAccess(2'd2, 16'h0000, 16'h1230, 1'b0); // R6 read
    tickDiv2 = 1'b1;                           // R8
    doAccess(2'd3, 16'h0000, 16'h4400, 1'b0);
    doAccess(2'd1, 16'h1357, 16'h0000, 1'b0);
    tickDiv2 = 1'b0;
    busWidth = 2'b00;                          // R9
    doAccess(2'd1, 16'hBEEF, 16'h0000, 1'b0);
    doAccess(2'd2, 16'h0000, 16'h7780, 1'b0);
    busWidth = 2'b11;
    // R12 zero cycle, R11 zero gap
    wrCycleTicks = 6'd0; csGapTicks = 6'd0;
    csOnTicks = 4'd0; csOffTicks = 6'd1; wrOnTicks = 4'd0; wrOffTicks = 6'd1;
    doAccess(2'd0, 16'h00C1, 16'h0000, 1'b0);
    // R11 longer gap with div2
    tickDiv2 = 1'b1; csGapTicks = 6'd5; wrCycleTicks = 6'd4; wrOffTicks = 6'd3;
    csOffTicks = 6'd4;
    doAccess(2'd1, 16'h2468, 16'h0000, 1'b0);

    repeat (20) @(negedge clk);
    chk(seen == pushed, "R10 access count", seen, pushed);
    chk(expQ.size() == 0, "R10 queue drained", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule